// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets several processors on one chip pass 32-bit messages to each other through a small set of hardware queues. A sender pushes a word by writing a queue's message register. A receiver pops the oldest word by reading that same register. Each queue has two read-only status words: one gives the number of words held, and the other flags when the queue is full.

Every processor, called a user here, has its own interrupt status word and its own enable mask. A push into queue m raises that queue's new-message event. A pop that takes queue m out of the full state raises its not-full event. Both events are latched in the status word of every user. Each user's interrupt line stays high while any enabled status bit is set. Software clears status bits by writing ones to them.

A configuration word holds two idle-control fields, which are only stored, and a soft-reset bit. The soft-reset bit empties the block and then clears itself. A system status word reports when the reset has finished. A fixed revision word identifies the block.

Register access uses a command channel with valid/ready handshaking. A command moves when `cmd_valid` and `cmd_ready` are both high at a clock edge. A master that sees `cmd_ready` low must hold its command and keep `cmd_valid` asserted. The block pulls `cmd_ready` low only while a soft reset is in progress. Each accepted read returns exactly one response beat on the following cycle. That response has no ready input and cannot be stalled. Accepted writes return no response.

Top module: `ipc_mailbox`

## Requirements
- R1: After the reset input is released, the following hold:
  - every queue is empty;
  - every status and enable word is zero;
  - the configuration word reads 0;
  - the system status word (byte offset 0x014) reads 1;
  - the revision word (offset 0x000) reads 0x20, with the major number in bits 7:4 and the minor number in bits 3:0;
  - all interrupt lines are low;
  - `cmd_ready` is high.
- R2: Queue m (m = 0..3) is pushed by writing offset 0x040+4m and popped by reading that same offset. Words come out in the order they went in, with all 32 bits intact, and each queue works independently of the others. Each queue holds up to 4 words.
- R3: A write to a full queue is dropped and raises no event. A read from an empty queue returns 0 and leaves the queue unchanged.
- R4: The word at offset 0x0C0+4m returns queue m's word count (0 to 4) in its low bits. The word at offset 0x080+4m returns 1 exactly when that count is 4, and 0 otherwise.
- R5: Each accepted push into queue m sets bit 2m of every user's status word.
- R6: A pop that takes queue m from 4 words to 3 sets bit 2m+1 of every user's status word. A pop that starts from any other count sets nothing.
- R7: The status word of user u is at offset 0x100+8u and reads its current value. Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged.
- R8: The enable word of user u is at offset 0x104+8u. It is read/write and stores its low 8 bits. `irq_o[u]` is high exactly when status(u) AND enable(u) is nonzero. Enable words are independent for each user.
- R9: Writing the configuration word (offset 0x010) with bit 1 set starts a soft reset, with these effects:
  - `cmd_ready` goes low for the next 2 cycles;
  - all queues, status words, enable words and idle fields are cleared at the edge where the write is accepted;
  - system status bit 0 reads 0 during the soft reset and 1 once it ends;
  - bit 1 of the configuration word reads 0 afterwards.
- R10: A configuration write with bit 1 clear stores bit 0 (auto-idle) and bits 4:3 (idle mode). These bits read back as written. All other configuration bits read 0.
- R11: An accepted read produces `rsp_valid` high with its data on the next cycle. `rsp_valid` is low in every cycle that does not follow an accepted read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (low during soft reset) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 9 | Byte offset of the register |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 4 | One interrupt line per user |

## Verification
The assertions assume the following about the master:
- it drives word-aligned offsets;
- it never raises `cmd_valid` during reset;
- it holds a command steady while `cmd_ready` is low.

The stimulus meets these assumptions by construction. It changes the command only at falling edges, and waits on `cmd_ready` before presenting each command. It uses only aligned offsets from the register layout, plus one aligned unmapped offset.

The random phase mixes pushes, pops, status clears and enable writes across all four queues and all four users. Queues therefore overflow and underflow while their interrupt lines toggle, and every response and every interrupt line is compared with a behavioural model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Register byte offsets; the strides are part of the software contract.
  localparam int OFS_REV      = 'h000;
  localparam int OFS_CFG      = 'h010;
  localparam int OFS_SYS      = 'h014;
  localparam int OFS_MSG      = 'h040;
  localparam int OFS_FULL     = 'h080;
  localparam int OFS_CNT      = 'h0C0;
  localparam int OFS_IRQ      = 'h100;
  localparam int IRQ_STRIDE   = 8;
  localparam int IRQ_EN_OFS   = 4;

  // Configuration bit positions
  localparam int CFG_AUTOIDLE = 0;
  localparam int CFG_SRST     = 1;
  localparam int CFG_MODE_LO  = 3;

  typedef struct packed {
    logic       auto_idle;
    logic [1:0] idle_mode;
  } idle_cfg_t;

  function automatic int ev_newmsg(input int q);
    return 2 * q;
  endfunction

  function automatic int ev_notfull(input int q);
    return 2 * q + 1;
  endfunction
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [NEV-1:0] ev_set,
  input  logic           st_wr,
  input  logic           en_wr,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] status,
  output logic [NEV-1:0] enable,
  output logic           irq
);
  logic [NEV-1:0] clr_mask;

  assign clr_mask = st_wr ? wdata : '0;
  assign irq      = |(status & enable);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      status <= '0;
      enable <= '0;
    end else begin
      // a new event in the same cycle wins over a clear
      status <= (status & ~clr_mask) | ev_set;
      if (en_wr) enable <= wdata;
    end
  end
endmodule

// File: rtl/mbx_cfg_ctl.sv
module mbx_cfg_ctl
  import mbx_pkg::*;
#(
  parameter int SRST_LEN = 2,
  localparam int KW      = $clog2(SRST_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        w_srst,
  input  logic        w_auto,
  input  logic [1:0]  w_mode,
  output logic        busy,
  output logic        flush,
  output logic [31:0] cfg_rd,
  output logic [31:0] sys_rd
);
  idle_cfg_t   idle_q;
  logic [KW-1:0] cnt;
  logic        done_q;
  logic        start;

  assign start = cfg_wr && w_srst;
  assign busy  = (cnt != '0);
  assign flush = start || busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      idle_q <= '0;
      done_q <= 1'b1;
    end else if (start) begin
      cnt    <= KW'(SRST_LEN);
      idle_q <= '0;
      done_q <= 1'b0;
    end else if (cfg_wr) begin
      idle_q.auto_idle <= w_auto;
      idle_q.idle_mode <= w_mode;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == KW'(1)) done_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rd = '0;
    cfg_rd[CFG_AUTOIDLE]              = idle_q.auto_idle;
    cfg_rd[CFG_SRST]                  = busy;
    cfg_rd[CFG_MODE_LO+1:CFG_MODE_LO] = idle_q.idle_mode;
    sys_rd    = '0;
    sys_rd[0] = done_q;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int          NUM_QUEUES = 4,
  parameter int          NUM_USERS  = 4,
  parameter int          DEPTH      = 4,
  parameter int          ADDR_W     = 9,
  parameter int          SRST_LEN   = 2,
  parameter logic [3:0]  REV_MAJOR  = 4'd2,
  parameter logic [3:0]  REV_MINOR  = 4'd0,
  localparam int         NEV        = 2 * NUM_QUEUES,
  localparam int         CW         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NUM_USERS-1:0] irq_o
);
  logic acc, acc_wr, acc_rd;
  logic busy, flush;
  logic [31:0] cfg_rd, sys_rd, rd_mux;

  logic [NUM_QUEUES-1:0]         hit_msg, hit_full, hit_cnt;
  logic [NUM_QUEUES-1:0]         q_push, q_pop, q_full, q_empty;
  logic [NUM_QUEUES-1:0][31:0]   q_head;
  logic [NUM_QUEUES-1:0][CW-1:0] q_count;
  logic [NUM_USERS-1:0]          hit_st, hit_en;
  logic [NUM_USERS-1:0][NEV-1:0] u_status, u_enable;
  logic [NEV-1:0]                ev_set;

  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign acc_wr    = acc && cmd_write;
  assign acc_rd    = acc && !cmd_write;

  mbx_cfg_ctl #(.SRST_LEN(SRST_LEN)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (acc_wr && (cmd_addr == ADDR_W'(OFS_CFG))),
    .w_srst (cmd_wdata[CFG_SRST]),
    .w_auto (cmd_wdata[CFG_AUTOIDLE]),
    .w_mode (cmd_wdata[CFG_MODE_LO+1:CFG_MODE_LO]),
    .busy   (busy),
    .flush  (flush),
    .cfg_rd (cfg_rd),
    .sys_rd (sys_rd)
  );

  for (genvar m = 0; m < NUM_QUEUES; m++) begin : g_q
    assign hit_msg[m]  = (cmd_addr == ADDR_W'(OFS_MSG  + 4 * m));
    assign hit_full[m] = (cmd_addr == ADDR_W'(OFS_FULL + 4 * m));
    assign hit_cnt[m]  = (cmd_addr == ADDR_W'(OFS_CNT  + 4 * m));
    assign q_push[m]   = acc_wr && hit_msg[m];
    assign q_pop[m]    = acc_rd && hit_msg[m];

    mbx_queue #(.DW(32), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (q_push[m]),
      .pop   (q_pop[m]),
      .wdata (cmd_wdata),
      .head  (q_head[m]),
      .count (q_count[m]),
      .full  (q_full[m]),
      .empty (q_empty[m])
    );

    assign ev_set[ev_newmsg(m)]  = q_push[m] && !q_full[m];
    assign ev_set[ev_notfull(m)] = q_pop[m] && q_full[m];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
    assign hit_st[u] = (cmd_addr == ADDR_W'(OFS_IRQ + IRQ_STRIDE * u));
    assign hit_en[u] = (cmd_addr == ADDR_W'(OFS_IRQ + IRQ_STRIDE * u + IRQ_EN_OFS));

    mbx_user_irq #(.NEV(NEV)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .ev_set (ev_set),
      .st_wr  (acc_wr && hit_st[u]),
      .en_wr  (acc_wr && hit_en[u]),
      .wdata  (cmd_wdata[NEV-1:0]),
      .status (u_status[u]),
      .enable (u_enable[u]),
      .irq    (irq_o[u])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (cmd_addr == ADDR_W'(OFS_REV)) rd_mux = {24'b0, REV_MAJOR, REV_MINOR};
    if (cmd_addr == ADDR_W'(OFS_CFG)) rd_mux = cfg_rd;
    if (cmd_addr == ADDR_W'(OFS_SYS)) rd_mux = sys_rd;
    for (int m = 0; m < NUM_QUEUES; m++) begin
      if (hit_msg[m])  rd_mux = q_head[m];
      if (hit_full[m]) rd_mux = 32'(q_full[m]);
      if (hit_cnt[m])  rd_mux = 32'(q_count[m]);
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (hit_st[u]) rd_mux = 32'(u_status[u]);
      if (hit_en[u]) rd_mux = 32'(u_enable[u]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int NU    = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 9,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic                  cmd_write,
  input logic [AW-1:0]         cmd_addr,
  input logic                  srst_bit,
  input logic                  rsp_valid,
  input logic [NU-1:0]         irq_o,
  input logic [NQ-1:0][CW-1:0] q_count
);
  logic acc_rd, srst_go;
  assign acc_rd  = cmd_valid && cmd_ready && !cmd_write;
  assign srst_go = cmd_valid && cmd_ready && cmd_write
                   && (cmd_addr == AW'(OFS_CFG)) && srst_bit;

  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);
  p_rsp_only_for_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rsp_valid);
  p_srst_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_go |=> !cmd_ready ##1 !cmd_ready);
  p_srst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_go |=> (irq_o == '0));

  for (genvar m = 0; m < NQ; m++) begin : g_chk
    logic hit;
    assign hit = (cmd_addr == AW'(OFS_MSG + 4 * m)) && cmd_valid && cmd_ready;
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_count[m] <= CW'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cmd_write && q_count[m] == CW'(DEPTH)) |=> (q_count[m] == CW'(DEPTH)));
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cmd_write && q_count[m] == '0) |=> (q_count[m] == '0));
  end
endmodule

bind ipc_mailbox mbx_checker u_mbx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .srst_bit  (cmd_wdata[1]),
  .rsp_valid (rsp_valid),
  .irq_o     (irq_o),
  .q_count   (q_count)
);

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] A_REV = 9'h000, A_CFG = 9'h010, A_SYS = 9'h014;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_write;
  logic        cmd_ready;
  logic [8:0]  cmd_addr;
  logic [31:0] cmd_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipc_mailbox uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural model
  logic [31:0] mq [4][$];
  logic [31:0] mst [4];
  logic [31:0] men [4];
  logic [31:0] mcfg;

  function automatic logic [8:0] a_msg(input int m);  return 9'(32'h40 + 4 * m); endfunction
  function automatic logic [8:0] a_full(input int m); return 9'(32'h80 + 4 * m); endfunction
  function automatic logic [8:0] a_cnt(input int m);  return 9'(32'hC0 + 4 * m); endfunction
  function automatic logic [8:0] a_st(input int u);   return 9'(32'h100 + 8 * u); endfunction
  function automatic logic [8:0] a_en(input int u);   return 9'(32'h104 + 8 * u); endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int u = 0; u < 4; u++) v[u] = |(mst[u] & men[u]);
    return v;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 4; i++) begin
      mq[i].delete();
      mst[i] = 0;
      men[i] = 0;
    end
    mcfg = 0;
  endfunction

  function automatic void model_write(input logic [8:0] a, input logic [31:0] d);
    for (int m = 0; m < 4; m++)
      if (a == a_msg(m) && mq[m].size() < 4) begin
        mq[m].push_back(d);
        for (int u = 0; u < 4; u++) mst[u][2*m] = 1'b1;
      end
    for (int u = 0; u < 4; u++) begin
      if (a == a_st(u)) mst[u] = mst[u] & ~(d & 32'hFF);
      if (a == a_en(u)) men[u] = d & 32'hFF;
    end
    if (a == A_CFG) begin
      if (d[1]) model_clear();
      else mcfg = d & 32'h19;
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [8:0] a);
    logic [31:0] r = 0;
    if (a == A_REV) r = 32'h20;
    if (a == A_CFG) r = mcfg;
    if (a == A_SYS) r = 1;
    for (int m = 0; m < 4; m++) begin
      if (a == a_full(m)) r = (mq[m].size() == 4) ? 1 : 0;
      if (a == a_cnt(m))  r = 32'(mq[m].size());
      if (a == a_msg(m) && mq[m].size() > 0) begin
        if (mq[m].size() == 4)
          for (int u = 0; u < 4; u++) mst[u][2*m+1] = 1'b1;
        r = mq[m].pop_front();
      end
    end
    for (int u = 0; u < 4; u++) begin
      if (a == a_st(u)) r = mst[u];
      if (a == a_en(u)) r = men[u];
    end
    return r;
  endfunction

  task automatic op(input bit w, input logic [8:0] a, input logic [31:0] d, input string r);
    logic [31:0] e = 0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    if (w) model_write(a, d);
    else   e = model_read(a);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({r, " R11 rsp_valid"}, 32'(rsp_valid), w ? 32'd0 : 32'd1);
    if (!w) chk({r, " data"}, rsp_rdata, e);
    chk("R8 irq lines", 32'(irq_o), 32'(exp_irq()));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    op(0, A_REV, 0, "R1 revision");
    op(0, A_SYS, 0, "R1 sysstatus");
    op(0, A_CFG, 0, "R1 config");
    op(0, a_cnt(0), 0, "R1 count");
    op(0, a_en(2), 0, "R1 enable");

    // R5/R8: new-message on q0 for user0, not-full on q0 for user1
    op(1, a_en(0), 32'h01, "R8 en0");
    op(1, a_en(1), 32'h02, "R8 en1");
    for (int i = 0; i < 4; i++) op(1, a_msg(0), 32'hA5A50000 + i, "R2 push q0");
    op(0, a_cnt(0), 0, "R4 count full");
    op(0, a_full(0), 0, "R4 full flag");
    op(1, a_msg(0), 32'hDEADBEEF, "R3 push to full");
    op(0, a_cnt(0), 0, "R3 count after drop");
    op(0, a_st(3), 0, "R5 status other user");
    op(0, a_msg(0), 0, "R2 pop order");
    op(0, a_st(1), 0, "R6 notfull set");
    op(0, a_full(0), 0, "R4 not full");
    for (int i = 0; i < 3; i++) op(0, a_msg(0), 0, "R2 drain q0");
    op(0, a_msg(0), 0, "R3 pop empty");
    op(0, a_cnt(0), 0, "R3 count stays 0");

    // R7 write-one-to-clear
    op(1, a_st(0), 32'h0, "R7 zero write");
    op(0, a_st(0), 0, "R7 unchanged");
    op(1, a_st(0), 32'h1, "R7 clear bit0");
    op(0, a_st(0), 0, "R7 after clear");

    // R2 queue independence
    op(1, a_msg(3), 32'h12345678, "R2 push q3");
    op(1, a_msg(1), 32'hCAFEF00D, "R2 push q1");
    op(0, a_msg(3), 0, "R2 pop q3");
    op(0, a_cnt(1), 0, "R4 q1 count");

    // R10 idle fields, R11 unmapped
    op(1, A_CFG, 32'h19, "R10 cfg write");
    op(0, A_CFG, 0, "R10 cfg read");
    op(1, A_CFG, 32'hFFFF_FFFD, "R10 cfg mask");
    op(0, A_CFG, 0, "R10 cfg masked");
    op(0, 9'h004, 0, "R11 unmapped");

    // R9 soft reset
    op(1, a_en(2), 32'hFF, "R9 setup");
    for (int i = 0; i < 3; i++) op(1, a_msg(2), i, "R9 fill");
    op(1, A_CFG, 32'h2, "R9 start");
    chk("R9 ready low 1", 32'(cmd_ready), 0);
    @(negedge clk);
    chk("R9 ready low 2", 32'(cmd_ready), 0);
    @(negedge clk);
    chk("R9 ready back", 32'(cmd_ready), 1);
    op(0, A_SYS, 0, "R9 done flag");
    op(0, A_CFG, 0, "R9 cfg cleared");
    op(0, a_cnt(2), 0, "R9 queue empty");
    op(0, a_en(2), 0, "R9 enable cleared");
    op(0, a_st(2), 0, "R9 status cleared");

    // random mix against the model
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 6);
      int q = $urandom_range(0, 3);
      logic [31:0] d = $urandom;
      case (k)
        0, 1: op(1, a_msg(q), d, "R2 rnd push");
        2, 3: op(0, a_msg(q), 0, "R2 rnd pop");
        4:    op(1, a_st(q), d, "R7 rnd clear");
        5:    op(1, a_en(q), d, "R8 rnd enable");
        default: op(0, (d[0] ? a_st(q) : a_cnt(q)), 0, "R4 rnd status");
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule